// File: doc/BRIEF.md
# Compare and Branch-Condition Unit

This unit serves an 8-bit processor core. It handles two instruction groups. The first is the compare instruction. It compares the result register S against a second register and writes four status bits into the flag register. The unit holds the flag register itself. The second group is the conditional jump. It tests one of eight predicates on the current flags and, when the predicate holds, pulses a branch strobe. With that strobe it presents the address-register value that the program counter must load.

The core presents one opcode per clock cycle. The register file supplies the S value and the register selected by the low three opcode bits. Other parts of the core (moves into the flag register, flag clearing, ALU results) write the flag register through a write-enable port.

Top module: `cmp_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `flags_out`, `take_branch` and `pc_target` become zero.
- R2: A compare opcode (`1111_0xxx`) sets flag bit 0 (zero) exactly when `s_val` is 0x00. The bit depends on `s_val` alone.
- R3: A compare sets flag bit 2 (parity) exactly when `s_val` has an even number of 1 bits. This includes 0x00. The bit depends on `s_val` alone.
- R4: A compare sets flag bit 3 (equal) exactly when `s_val` and `r_val` are bit-identical.
- R5: A compare sets flag bit 4 (greater) exactly when `s_val` is greater than `r_val`, with both read as unsigned.
- R6: A compare without a simultaneous flag write leaves flag bit 1 (carry) and bits 7..5 unchanged.
- R7: A jump opcode (`0010_0ccc`) raises `take_branch` for the one cycle after its edge, exactly when condition ccc holds on the flags. In that cycle `pc_target` equals the `addr_reg` sampled at the jump. The conditions are: 000 Z; 001 P; 010 !Z&G; 011 C; 100 Z|G; 101 Z|!G; 110 !Z&!G; 111 always.
- R8: A jump tests the flag value held before its own edge. A flag write in the same cycle does not affect the decision. A compare in the cycle just before is visible to the jump.
- R9: Any opcode that is neither a compare nor a jump leaves the flags unchanged when `flags_wr` is low, and leaves `take_branch` low.
- R10: When `flags_wr` is high, the flags load `flags_in` at the edge. If a compare executes in the same cycle, the compare results replace bits 0, 2, 3 and 4, and the other bits come from `flags_in`.
- R11: A jump never changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction byte executed this cycle |
| s_val | input | 8 | Contents of register S |
| r_val | input | 8 | Contents of the register picked by opcode bits 2..0 |
| addr_reg | input | 16 | Contents of the address register |
| flags_wr | input | 1 | Flag register write enable from the rest of the core |
| flags_in | input | 8 | Value to write into the flag register |
| flags_out | output | 8 | Current flag register |
| take_branch | output | 1 | One-cycle strobe: load the program counter |
| pc_target | output | 16 | Address to load while `take_branch` is high |

## Verification
Every result of this unit is due exactly one rising edge after its opcode is presented. This holds for the compare flags, flag writes, the branch strobe and the jump target. No other latency path exists. The bench drives each opcode on a falling edge and reads the outputs on the following falling edge. In that window the edge that consumes the stimulus has passed and the next one has not. The opcode returns to an idle value straight after, so each strobe check also confirms that the pulse lasts a single cycle. The same-edge test drives a jump together with a flag write. Reading the strobe one cycle later shows which flag value the jump decision used.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int FLG_Z = 0;
  localparam int FLG_C = 1;
  localparam int FLG_P = 2;
  localparam int FLG_E = 3;
  localparam int FLG_G = 4;

  localparam logic [4:0] OP_CMP_TOP = 5'b11110;
  localparam logic [4:0] OP_JMP_TOP = 5'b00100;

  typedef enum logic [2:0] {
    COND_ZERO   = 3'd0,
    COND_PARITY = 3'd1,
    COND_GT     = 3'd2,
    COND_CARRY  = 3'd3,
    COND_GE     = 3'd4,
    COND_LE     = 3'd5,
    COND_LT     = 3'd6,
    COND_ALWAYS = 3'd7
  } cond_e;

endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       is_cmp,
  output logic       is_jmp,
  output cond_e      cond
);
  always_comb begin
    is_cmp = (opcode[7:3] == OP_CMP_TOP);
    is_jmp = (opcode[7:3] == OP_JMP_TOP);
    cond   = cond_e'(opcode[2:0]);
  end
endmodule

// File: rtl/cbu_compare.sv
module cbu_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              zero,
  output logic              even_par,
  output logic              equal,
  output logic              greater
);
  logic [DATA_W:0] par_chain;

  assign par_chain[0] = 1'b0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ lhs[i];
  end

  always_comb begin
    zero     = (lhs == '0);
    even_par = ~par_chain[DATA_W];
    equal    = (lhs == rhs);
    greater  = (lhs > rhs);
  end
endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
  import cbu_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic [FLAG_W-1:0] flags,
  input  cond_e             cond,
  output logic              hit
);
  logic z, c, p, g;

  always_comb begin
    z = flags[FLG_Z];
    c = flags[FLG_C];
    p = flags[FLG_P];
    g = flags[FLG_G];
    unique case (cond)
      COND_ZERO:   hit = z;
      COND_PARITY: hit = p;
      COND_GT:     hit = !z && g;
      COND_CARRY:  hit = c;
      COND_GE:     hit = z || g;
      COND_LE:     hit = z || !g;
      COND_LT:     hit = !z && !g;
      default:     hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] s_val,
  input  logic [DATA_W-1:0] r_val,
  input  logic [ADDR_W-1:0] addr_reg,
  input  logic              flags_wr,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic              take_branch,
  output logic [ADDR_W-1:0] pc_target
);
  logic              is_cmp, is_jmp, hit;
  cond_e             cond;
  logic              c_zero, c_par, c_eq, c_gt;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              take_q;
  logic [ADDR_W-1:0] target_q;

  cbu_decode u_dec (
    .opcode (opcode),
    .is_cmp (is_cmp),
    .is_jmp (is_jmp),
    .cond   (cond)
  );

  cbu_compare #(.DATA_W(DATA_W)) u_cmp (
    .lhs      (s_val),
    .rhs      (r_val),
    .zero     (c_zero),
    .even_par (c_par),
    .equal    (c_eq),
    .greater  (c_gt)
  );

  cbu_cond #(.FLAG_W(FLAG_W)) u_cond (
    .flags (flags_q),
    .cond  (cond),
    .hit   (hit)
  );

  always_comb begin
    flags_d = flags_q;
    if (flags_wr) flags_d = flags_in;
    if (is_cmp) begin
      flags_d[FLG_Z] = c_zero;
      flags_d[FLG_P] = c_par;
      flags_d[FLG_E] = c_eq;
      flags_d[FLG_G] = c_gt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      take_q   <= 1'b0;
      target_q <= '0;
    end else begin
      flags_q <= flags_d;
      take_q  <= is_jmp && hit;
      if (is_jmp) target_q <= addr_reg;
    end
  end

  assign flags_out   = flags_q;
  assign take_branch = take_q;
  assign pc_target   = target_q;
endmodule

// File: rtl/cbu_checks.sv
module cbu_checks #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] s_val,
  input logic [DATA_W-1:0] r_val,
  input logic [ADDR_W-1:0] addr_reg,
  input logic              flags_wr,
  input logic [FLAG_W-1:0] flags_out,
  input logic              take_branch,
  input logic [ADDR_W-1:0] pc_target
);
  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode[7:3]) == 5'b11110) |-> flags_out[0] == ($past(s_val) == '0));

  p_equal_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode[7:3]) == 5'b11110) |-> flags_out[3] == ($past(s_val) == $past(r_val)));

  p_greater_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode[7:3]) == 5'b11110) |-> flags_out[4] == ($past(s_val) > $past(r_val)));

  p_keep_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode[7:3]) == 5'b11110 && !$past(flags_wr))
      |-> (flags_out[1] == $past(flags_out[1]) && flags_out[7:5] == $past(flags_out[7:5])));

  p_strobe_src_r7: assert property (@(posedge clk) disable iff (rst)
    take_branch |-> (!$past(rst) && $past(opcode[7:3]) == 5'b00100));

  p_target_r7: assert property (@(posedge clk) disable iff (rst)
    take_branch |-> pc_target == $past(addr_reg));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode[7:3]) != 5'b11110 && !$past(flags_wr)) |-> $stable(flags_out));
endmodule

bind cmp_branch_unit cbu_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .s_val(s_val), .r_val(r_val),
  .addr_reg(addr_reg), .flags_wr(flags_wr), .flags_out(flags_out),
  .take_branch(take_branch), .pc_target(pc_target)
);

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  s_val = 8'h00, r_val = 8'h00;
  logic [15:0] addr_reg = 16'h0000;
  logic        flags_wr = 1'b0;
  logic [7:0]  flags_in = 8'h00;
  logic [7:0]  flags_out;
  logic        take_branch;
  logic [15:0] pc_target;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cmp_branch_unit u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .s_val(s_val), .r_val(r_val),
    .addr_reg(addr_reg), .flags_wr(flags_wr), .flags_in(flags_in),
    .flags_out(flags_out), .take_branch(take_branch), .pc_target(pc_target)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then return inputs to idle; outputs sampled after
  task automatic cycle(input logic [7:0] op, input logic [7:0] s, input logic [7:0] r,
                       input logic [15:0] a, input logic wr, input logic [7:0] fin);
    opcode = op; s_val = s; r_val = r; addr_reg = a; flags_wr = wr; flags_in = fin;
    @(negedge clk);
    opcode = 8'h00; flags_wr = 1'b0;
  endtask

  function automatic logic even_ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return (n % 2) == 0;
  endfunction

  function automatic logic cond_ok(input logic [2:0] c, input logic [7:0] f);
    logic z, cy, p, g;
    z = f[0]; cy = f[1]; p = f[2]; g = f[4];
    case (c)
      3'd0: return z;
      3'd1: return p;
      3'd2: return !z && g;
      3'd3: return cy;
      3'd4: return z || g;
      3'd5: return z || !g;
      3'd6: return !z && !g;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_reset();
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'hFF);
    rst = 1'b1;
    cycle(8'h27, 8'h00, 8'h00, 16'hBEEF, 1'b0, 8'h00);
    chk("R1 flags", {8'h0, flags_out}, 16'h0);
    chk("R1 strobe", {15'h0, take_branch}, 16'h0);
    chk("R1 target", pc_target, 16'h0);
    rst = 1'b0;
  endtask

  task automatic t_compare_patterns();
    logic [7:0] sv [8] = '{8'h00, 8'h01, 8'h03, 8'hFF, 8'h80, 8'h7E, 8'h55, 8'hA0};
    logic [7:0] rv [8] = '{8'h00, 8'h02, 8'h03, 8'hFE, 8'h81, 8'h00, 8'h55, 8'hFF};
    for (int i = 0; i < 8; i++) begin
      cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'h00);
      cycle(8'hF0 | 8'(i), sv[i], rv[i], 16'h0, 1'b0, 8'h00);
      chk("R2 zero", {15'h0, flags_out[0]}, {15'h0, sv[i] == 8'h00});
      chk("R3 parity", {15'h0, flags_out[2]}, {15'h0, even_ones(sv[i])});
      chk("R4 equal", {15'h0, flags_out[3]}, {15'h0, sv[i] == rv[i]});
      chk("R5 greater", {15'h0, flags_out[4]}, {15'h0, sv[i] > rv[i]});
    end
  endtask

  task automatic t_keep_bits();
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'hE2);
    cycle(8'hF3, 8'h10, 8'h10, 16'h0, 1'b0, 8'h00);
    // S=0x10: Z=0, P=0 (one bit), E=1, G=0 ; carry and 7..5 kept
    chk("R6 keep", {8'h0, flags_out}, 16'h00EA);
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'h00);
    cycle(8'hF7, 8'hFF, 8'h00, 16'h0, 1'b0, 8'h00);
    chk("R6 keep clear", {8'h0, flags_out}, 16'h0014);
  endtask

  task automatic t_jump_conds();
    for (int fz = 0; fz < 16; fz++) begin
      logic [7:0] f;
      f = {3'b000, fz[3], 1'b0, fz[2], fz[1], fz[0]};
      for (int c = 0; c < 8; c++) begin
        logic [15:0] a;
        a = 16'h1000 + 16'(fz * 8 + c);
        cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, f);
        cycle(8'h20 | 8'(c), 8'h00, 8'h00, a, 1'b0, 8'h00);
        chk("R7 taken", {15'h0, take_branch}, {15'h0, cond_ok(3'(c), f)});
        if (cond_ok(3'(c), f)) chk("R7 target", pc_target, a);
        chk("R11 flags", {8'h0, flags_out}, {8'h0, f});
        @(negedge clk);
        chk("R7 single pulse", {15'h0, take_branch}, 16'h0);
      end
    end
  endtask

  task automatic t_pre_edge();
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'h00);
    cycle(8'h20, 8'h00, 8'h00, 16'h2222, 1'b1, 8'h01);
    chk("R8 same edge", {15'h0, take_branch}, 16'h0);
    chk("R8 write landed", {8'h0, flags_out}, 16'h0001);
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'h00);
    cycle(8'hF1, 8'h00, 8'h05, 16'h0, 1'b0, 8'h00);
    cycle(8'h20, 8'h00, 8'h00, 16'h3333, 1'b0, 8'h00);
    chk("R8 after compare", {15'h0, take_branch}, 16'h1);
    chk("R8 target", pc_target, 16'h3333);
  endtask

  task automatic t_other_ops();
    logic [7:0] ops [6] = '{8'h00, 8'h28, 8'h35, 8'h4F, 8'hE8, 8'hFF};
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'h9D);
    for (int i = 0; i < 6; i++) begin
      cycle(ops[i], 8'h00, 8'h00, 16'h4444, 1'b0, 8'h00);
      chk("R9 flags held", {8'h0, flags_out}, 16'h009D);
      chk("R9 no strobe", {15'h0, take_branch}, 16'h0);
    end
  endtask

  task automatic t_write_merge();
    cycle(8'h00, 8'h00, 8'h00, 16'h0, 1'b1, 8'h5A);
    chk("R10 plain write", {8'h0, flags_out}, 16'h005A);
    // compare S=3 R=1: Z=0 P=1 E=0 G=1 ; rest from flags_in 0xFF
    cycle(8'hF2, 8'h03, 8'h01, 16'h0, 1'b1, 8'hFF);
    chk("R10 merge", {8'h0, flags_out}, 16'hF6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_compare_patterns();
    t_keep_bits();
    t_jump_conds();
    t_pre_edge();
    t_other_ops();
    t_write_merge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule